// File: doc/BRIEF.md
# Parallel ATA PIO Bus Cycle Generator

This block turns a single-beat host register request into one programmed-I/O bus cycle toward a parallel ATA device. It decodes the host offset into a command-block or control-block access, places the device register index on a three-bit address, frames the access with the matching chip select, and pulses a read or write strobe. On a read it captures the 16-bit device data bus. On a write it drives that bus through an output enable. A ready input from the device can stretch the strobe.

Setup, strobe pulse and cycle length come from three clock-count registers. These reset to mode-0 counts for a 250 MHz clock and can be rewritten through a small configuration port. Fixed rules correct the programmed counts before use. The strobe setup gets one extra clock. A pulse of zero counts as one clock. The cycle is lengthened so that at least two recovery clocks follow the strobe. The host sees one acknowledge pulse when the whole cycle, recovery included, has finished.

Period numbering used below: a request is accepted on a clock edge where the block is idle. Period 0 is the clock period that starts at that edge, and period k is the k-th period after it. With S = setup+1, P = max(pulse,1), A = S+P and C = max(cycle, A+2), an unstretched cycle runs through periods 0 to C-1.

Top module: `pata_pio_seq`

## Requirements
- R1: An offset with bits [23:21] = 3'b110 (0xC00000 to 0xDFFFFF) selects the command block: `cmd_cs_n` goes low. Bits [23:21] = 3'b111 select the control block: `ctl_cs_n` goes low. The two selects are never low together.
- R2: `reg_a` equals host offset bits [3:1] from acceptance onward, and it is stable while the selected chip select is low. The alternate status and device control register (control block, index 6) is therefore reached at offset 0xE0000C.
- R3: The strobe is low in periods S to A-1, where S = setup+1 and P = max(pulse,1).
- R4: The cycle length is C = max(cycle, A+2). `req_ack` is high for exactly one clock, in period C.
- R5: The selected chip select is low in periods 1 to C-2 and high in periods 0 and C-1.
- R6: A write uses the same S, A and C as a read. It pulses `wr_stb_n` in place of `rd_stb_n`, and the two strobes are never low together.
- R7: Read data is captured on the clock edge that ends the last low period of `rd_stb_n`. `req_rdata` then holds that value until the next read.
- R8: Each clock edge at which the strobe is low and `dev_rdy` is low adds one period to the strobe. The chip select window and the cycle grow by the same amount.
- R9: The data register (command block, index 0) is transferred on all 16 bits. For every other register, a write drives the upper byte of `bus_dout` as zero and a read returns the upper byte of `req_rdata` as zero.
- R10: After reset, both chip selects and both strobes are high, `bus_oe` and `req_ack` are low, and the timing registers hold setup 18, pulse 73 and cycle 150.
- R11: A request that arrives while a cycle is in progress is dropped, with no effect on the bus. A request that arrives in the acknowledge period is accepted, and its period 0 is the next clock.
- R12: A request whose offset lies below 0xC00000 causes no chip select, no strobe and no acknowledge.
- R13: On a write, `bus_oe` is high exactly while the chip select is low. On a read it stays low.
- R14: A configuration write made during a cycle leaves that cycle's timing unchanged and applies to the cycles accepted after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Host byte offset |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-clock completion pulse |
| req_rdata | output | 16 | Captured read data |
| tcfg_we | input | 1 | Loads the three timing counts |
| tcfg_setup | input | 8 | Programmed setup count |
| tcfg_pulse | input | 8 | Programmed strobe pulse count |
| tcfg_cycle | input | 8 | Programmed total cycle count |
| cmd_cs_n | output | 1 | Command-block select, active low |
| ctl_cs_n | output | 1 | Control-block select, active low |
| reg_a | output | 3 | Device register index |
| rd_stb_n | output | 1 | Read strobe, active low |
| wr_stb_n | output | 1 | Write strobe, active low |
| bus_dout | output | 16 | Device data bus, outgoing |
| bus_oe | output | 1 | Output enable for `bus_dout` |
| bus_din | input | 16 | Device data bus, incoming |
| dev_rdy | input | 1 | Device ready, low stretches the strobe |

## Verification
The acknowledge of one cycle and the acceptance of the next request can fall on the same clock. This is provoked by raising a new request in the very period where `req_ack` is seen high. The result is judged by requiring the second cycle's chip select, strobe and acknowledge to land at periods counted from the clock right after that acknowledge. A second overlap is a ready stretch that ends in the last strobe period. There the read capture must take the bus value present at the final edge, and the bench drives a different value on `bus_din` in every period so that this can be seen.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_CMD  = 2'd1,
    RGN_CTL  = 2'd2
  } rgn_e;

endpackage

// File: rtl/pata_addr_decode.sv
module pata_addr_decode
  import pata_pio_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr,
  output rgn_e              region,
  output logic [2:0]        idx,
  output logic              wide
);
  localparam logic [ADDR_W-1:0] CMD_BASE = ADDR_W'(3'b110) << (ADDR_W - 3);
  localparam logic [ADDR_W-1:0] CTL_BASE = ADDR_W'(3'b111) << (ADDR_W - 3);

  always_comb begin
    if (addr >= CTL_BASE)      region = RGN_CTL;
    else if (addr >= CMD_BASE) region = RGN_CMD;
    else                       region = RGN_NONE;
    idx  = addr[3:1];
    wide = (region == RGN_CMD) && (idx == 3'd0);
  end
endmodule

// File: rtl/pata_timing_regs.sv
module pata_timing_regs #(
  parameter int CNT_W     = 8,
  parameter int SPAN_W    = CNT_W + 2,
  parameter int RST_SETUP = 18,
  parameter int RST_PULSE = 73,
  parameter int RST_CYCLE = 150
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CNT_W-1:0]  setup_in,
  input  logic [CNT_W-1:0]  pulse_in,
  input  logic [CNT_W-1:0]  cycle_in,
  output logic [SPAN_W-1:0] strb_on,
  output logic [SPAN_W-1:0] strb_off,
  output logic [SPAN_W-1:0] cyc_len
);
  logic [CNT_W-1:0]  setup_q, pulse_q, cycle_q;
  logic [SPAN_W-1:0] pulse_eff, min_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      setup_q <= CNT_W'(RST_SETUP);
      pulse_q <= CNT_W'(RST_PULSE);
      cycle_q <= CNT_W'(RST_CYCLE);
    end else if (we) begin
      setup_q <= setup_in;
      pulse_q <= pulse_in;
      cycle_q <= cycle_in;
    end
  end

  // Corrections: extra setup clock, pulse floor of one, two-clock recovery floor
  always_comb begin
    strb_on   = SPAN_W'(setup_q) + SPAN_W'(1);
    pulse_eff = (pulse_q == '0) ? SPAN_W'(1) : SPAN_W'(pulse_q);
    strb_off  = strb_on + pulse_eff;
    min_len   = strb_off + SPAN_W'(2);
    cyc_len   = (SPAN_W'(cycle_q) < min_len) ? min_len : SPAN_W'(cycle_q);
  end
endmodule

// File: rtl/pata_strobe_seq.sv
module pata_strobe_seq #(
  parameter int SPAN_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SPAN_W-1:0] on_in,
  input  logic [SPAN_W-1:0] off_in,
  input  logic [SPAN_W-1:0] len_in,
  input  logic              rdy,
  output logic              busy,
  output logic              last,
  output logic              cs_nxt,
  output logic              strb_nxt,
  output logic              strb_cur
);
  logic [SPAN_W-1:0] cnt, nxt_cnt, on_q, off_q, len_q, on_u, off_u, len_u;
  logic              hold, nxt_busy;

  always_comb begin
    hold  = busy && strb_cur && !rdy;
    last  = busy && !hold && (cnt == len_q - SPAN_W'(1));
    on_u  = start ? on_in  : on_q;
    off_u = start ? off_in : off_q;
    len_u = start ? len_in : len_q;
    if (start) begin
      nxt_cnt  = '0;
      nxt_busy = 1'b1;
    end else if (last) begin
      nxt_cnt  = cnt;
      nxt_busy = 1'b0;
    end else if (busy && !hold) begin
      nxt_cnt  = cnt + SPAN_W'(1);
      nxt_busy = 1'b1;
    end else begin
      nxt_cnt  = cnt;
      nxt_busy = busy;
    end
    cs_nxt   = nxt_busy && (nxt_cnt != '0) && (nxt_cnt <= len_u - SPAN_W'(2));
    strb_nxt = nxt_busy && (nxt_cnt >= on_u) && (nxt_cnt < off_u);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      strb_cur <= 1'b0;
      on_q     <= '0;
      off_q    <= '0;
      len_q    <= '0;
    end else begin
      busy     <= nxt_busy;
      cnt      <= nxt_cnt;
      strb_cur <= strb_nxt;
      if (start) begin
        on_q  <= on_in;
        off_q <= off_in;
        len_q <= len_in;
      end
    end
  end

  // R8
  wait_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && strb_cur && !rdy) |=> $stable(cnt));

  // R4
  end_idle_chk: assert property (@(posedge clk) disable iff (rst)
    last |=> !busy);
endmodule

// File: rtl/pata_pio_seq.sv
module pata_pio_seq
  import pata_pio_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 8,
  parameter int RST_SETUP = 18,
  parameter int RST_PULSE = 73,
  parameter int RST_CYCLE = 150
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic [DATA_W-1:0] req_rdata,
  input  logic              tcfg_we,
  input  logic [CNT_W-1:0]  tcfg_setup,
  input  logic [CNT_W-1:0]  tcfg_pulse,
  input  logic [CNT_W-1:0]  tcfg_cycle,
  output logic              cmd_cs_n,
  output logic              ctl_cs_n,
  output logic [2:0]        reg_a,
  output logic              rd_stb_n,
  output logic              wr_stb_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              dev_rdy
);
  localparam int SPAN_W = CNT_W + 2;
  localparam int LANE_W = 8;
  localparam int HIGH_W = DATA_W - LANE_W;

  rgn_e              region, rgn_q, rgn_u;
  logic [2:0]        idx;
  logic              wide, wide_q, wr_q, wr_u, accept;
  logic [SPAN_W-1:0] t_on, t_off, t_len;
  logic              busy, last, cs_nxt, strb_nxt, strb_cur;
  logic [DATA_W-1:0] wr_lane, rd_lane;

  pata_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .region(region), .idx(idx), .wide(wide)
  );

  pata_timing_regs #(
    .CNT_W(CNT_W), .SPAN_W(SPAN_W),
    .RST_SETUP(RST_SETUP), .RST_PULSE(RST_PULSE), .RST_CYCLE(RST_CYCLE)
  ) u_tim (
    .clk(clk), .rst(rst), .we(tcfg_we),
    .setup_in(tcfg_setup), .pulse_in(tcfg_pulse), .cycle_in(tcfg_cycle),
    .strb_on(t_on), .strb_off(t_off), .cyc_len(t_len)
  );

  pata_strobe_seq #(.SPAN_W(SPAN_W)) u_seq (
    .clk(clk), .rst(rst), .start(accept),
    .on_in(t_on), .off_in(t_off), .len_in(t_len), .rdy(dev_rdy),
    .busy(busy), .last(last), .cs_nxt(cs_nxt),
    .strb_nxt(strb_nxt), .strb_cur(strb_cur)
  );

  always_comb begin
    accept  = !busy && req_valid && (region != RGN_NONE);
    rgn_u   = accept ? region : rgn_q;
    wr_u    = accept ? req_write : wr_q;
    wr_lane = wide ? req_wdata : {{HIGH_W{1'b0}}, req_wdata[LANE_W-1:0]};
    rd_lane = wide_q ? bus_din : {{HIGH_W{1'b0}}, bus_din[LANE_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rgn_q     <= RGN_NONE;
      wr_q      <= 1'b0;
      wide_q    <= 1'b0;
      reg_a     <= '0;
      bus_dout  <= '0;
      req_rdata <= '0;
      req_ack   <= 1'b0;
      cmd_cs_n  <= 1'b1;
      ctl_cs_n  <= 1'b1;
      rd_stb_n  <= 1'b1;
      wr_stb_n  <= 1'b1;
      bus_oe    <= 1'b0;
    end else begin
      if (accept) begin
        rgn_q    <= region;
        wr_q     <= req_write;
        wide_q   <= wide;
        reg_a    <= idx;
        bus_dout <= wr_lane;
      end
      if (busy && strb_cur && !strb_nxt && !wr_q)
        req_rdata <= rd_lane;
      req_ack  <= last;
      cmd_cs_n <= !(cs_nxt && rgn_u == RGN_CMD);
      ctl_cs_n <= !(cs_nxt && rgn_u == RGN_CTL);
      rd_stb_n <= !(strb_nxt && !wr_u);
      wr_stb_n <= !(strb_nxt && wr_u);
      bus_oe   <= cs_nxt && wr_u;
    end
  end

  // R1
  cs_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~cmd_cs_n, ~ctl_cs_n}));

  // R5
  stb_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_stb_n || !wr_stb_n) |-> (!cmd_cs_n || !ctl_cs_n));

  // R6
  rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rd_stb_n && !wr_stb_n));

  // R13
  oe_frame_chk: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> (!cmd_cs_n || !ctl_cs_n));

  // R4
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);

  // R11
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> $stable(reg_a));

  // R12
  miss_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid && region == RGN_NONE) |=> !busy);
endmodule

// File: tb/tb_pata_pio_seq.sv
`timescale 1ns/1ps
module tb_pata_pio_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ack;
  logic [15:0] req_rdata;
  logic        tcfg_we = 1'b0;
  logic [7:0]  tcfg_setup = '0, tcfg_pulse = '0, tcfg_cycle = '0;
  logic        cmd_cs_n, ctl_cs_n, rd_stb_n, wr_stb_n, bus_oe;
  logic [2:0]  reg_a;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = '0;
  logic        dev_rdy = 1'b1;

  always #2 clk = ~clk;

  pata_pio_seq dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .req_rdata(req_rdata), .tcfg_we(tcfg_we), .tcfg_setup(tcfg_setup),
    .tcfg_pulse(tcfg_pulse), .tcfg_cycle(tcfg_cycle), .cmd_cs_n(cmd_cs_n),
    .ctl_cs_n(ctl_cs_n), .reg_a(reg_a), .rd_stb_n(rd_stb_n),
    .wr_stb_n(wr_stb_n), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .bus_din(bus_din), .dev_rdy(dev_rdy)
  );

  int n_chk = 0, n_bad = 0;
  int m_set = 18, m_pul = 73, m_cyc = 150;
  int eS, eA, eC;
  logic [2:0]  exp_da;
  logic [15:0] exp_dout;
  int cmd_f, cmd_l, ctl_f, ctl_l, stb_f, stb_l, rd_n, wr_n, oe_f, oe_l;
  int ack_at, ack_n, da_bad, dout_bad;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model();
    int p;
    eS = m_set + 1;
    p  = (m_pul == 0) ? 1 : m_pul;
    eA = eS + p;
    eC = (m_cyc < eA + 2) ? eA + 2 : m_cyc;
  endtask

  task automatic set_cfg(int s, int p, int c);
    @(negedge clk);
    tcfg_we = 1'b1; tcfg_setup = 8'(s); tcfg_pulse = 8'(p); tcfg_cycle = 8'(c);
    @(negedge clk);
    tcfg_we = 1'b0;
    m_set = s; m_pul = p; m_cyc = c;
  endtask

  task automatic launch(logic [23:0] a, bit w, logic [15:0] d, int hold);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d;
    dev_rdy = (hold == 0);
    exp_da = a[3:1];
  endtask

  task automatic observe(int hold, bit poke, bit cfgpoke, bit chain,
                         logic [23:0] c_addr, bit c_wr);
    int low = 0;
    bit done = 0;
    cmd_f = -1; cmd_l = -1; ctl_f = -1; ctl_l = -1; stb_f = -1; stb_l = -1;
    oe_f = -1; oe_l = -1; ack_at = -1; ack_n = 0; rd_n = 0; wr_n = 0;
    da_bad = 0; dout_bad = 0;
    for (int p = 0; p < 700 && !done; p++) begin
      @(negedge clk);
      if (p == 0) req_valid = 1'b0;
      if (!cmd_cs_n) begin if (cmd_f < 0) cmd_f = p; cmd_l = p; end
      if (!ctl_cs_n) begin if (ctl_f < 0) ctl_f = p; ctl_l = p; end
      if ((!cmd_cs_n || !ctl_cs_n) && reg_a != exp_da) da_bad++;
      if (!rd_stb_n) rd_n++;
      if (!wr_stb_n) wr_n++;
      if (!rd_stb_n || !wr_stb_n) begin
        if (stb_f < 0) stb_f = p;
        stb_l = p;
        low++;
        if (hold > 0 && low == hold) dev_rdy = 1'b1;
      end
      if (bus_oe) begin
        if (oe_f < 0) oe_f = p;
        oe_l = p;
        if (bus_dout != exp_dout) dout_bad++;
      end
      if (req_ack) begin ack_n++; ack_at = p; done = 1; end
      bus_din = 16'h5A00 | 16'(p & 255);
      if (poke && p == 5) begin req_valid = 1'b1; req_addr = 24'hE00004; req_write = 1'b1; end
      if (poke && p == 6) req_valid = 1'b0;
      if (cfgpoke && p == 2) begin
        tcfg_we = 1'b1; tcfg_setup = 8'd1; tcfg_pulse = 8'd2; tcfg_cycle = 8'd30;
      end
      if (cfgpoke && p == 3) tcfg_we = 1'b0;
      if (chain && done) begin
        req_valid = 1'b1; req_addr = c_addr; req_write = c_wr; exp_da = c_addr[3:1];
      end
    end
  endtask

  task automatic check_frame(string tag, bit is_ctl, bit is_wr, int ext);
    int ef = 1, el = eC - 2 + ext;
    check({tag, " R1/R5 sel first"}, is_ctl ? ctl_f : cmd_f, ef);
    check({tag, " R5 sel last"}, is_ctl ? ctl_l : cmd_l, el);
    check({tag, " R1 other sel idle"}, is_ctl ? cmd_f : ctl_f, -1);
    check({tag, " R3 strobe first"}, stb_f, eS);
    check({tag, " R3/R8 strobe last"}, stb_l, eA - 1 + ext);
    check({tag, " R6 strobe kind"}, is_wr ? rd_n : wr_n, 0);
    check({tag, " R13 oe first"}, oe_f, is_wr ? ef : -1);
    check({tag, " R13 oe last"}, oe_l, is_wr ? el : -1);
    check({tag, " R4 ack period"}, ack_at, eC + ext);
    check({tag, " R4 ack count"}, ack_n, 1);
    check({tag, " R2 address stable"}, da_bad, 0);
    check({tag, " R9 dout lanes"}, dout_bad, 0);
  endtask

  task automatic t_reset();
    check("R10 reset cmd_cs_n", int'(cmd_cs_n), 1);
    check("R10 reset ctl_cs_n", int'(ctl_cs_n), 1);
    check("R10 reset strobes", int'(rd_stb_n & wr_stb_n), 1);
    check("R10 reset oe/ack", int'(bus_oe | req_ack), 0);
  endtask

  task automatic t_default_read();
    model();
    check("R10 default cycle len", eC, 150);
    launch(24'hC0000E, 0, 16'h0, 0);
    observe(0, 0, 0, 0, '0, 0);
    check_frame("default read", 0, 0, 0);
    check("R7/R9 default read data", int'(req_rdata), int'(16'h00FF & 16'(eA - 1)));
  endtask

  task automatic t_ctl_read();
    model();
    launch(24'hE0000C, 0, 16'h0, 0);
    observe(0, 0, 0, 0, '0, 0);
    check_frame("ctl read", 1, 0, 0);
    check("R2 ctl index", int'(exp_da), 6);
    check("R9 ctl read data", int'(req_rdata), int'(16'(eA - 1)));
  endtask

  task automatic t_data_write();
    model();
    exp_dout = 16'hA55A;
    launch(24'hC00000, 1, 16'hA55A, 0);
    observe(0, 0, 0, 0, '0, 0);
    check_frame("data write R6", 0, 1, 0);
  endtask

  task automatic t_reg_write();
    model();
    exp_dout = 16'h00EF;
    launch(24'hC00002, 1, 16'hBEEF, 0);
    observe(0, 0, 0, 0, '0, 0);
    check_frame("reg write R9", 0, 1, 0);
  endtask

  task automatic t_data_read();
    model();
    launch(24'hC00000, 0, 16'h0, 0);
    observe(0, 0, 0, 0, '0, 0);
    check_frame("data read", 0, 0, 0);
    check("R7/R9 wide read data", int'(req_rdata), int'(16'h5A00 | 16'(eA - 1)));
  endtask

  task automatic t_busy_ignore();
    int stray = 0;
    model();
    exp_dout = 16'h1234;
    launch(24'hC00000, 1, 16'h1234, 0);
    observe(0, 1, 0, 0, '0, 0);
    check_frame("busy drop R11", 0, 1, 0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!cmd_cs_n || !ctl_cs_n || req_ack || !wr_stb_n) stray++;
    end
    check("R11 dropped request leaves bus idle", stray, 0);
  endtask

  task automatic t_window();
    int act = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 24'h400000; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!cmd_cs_n || !ctl_cs_n || !rd_stb_n || !wr_stb_n || req_ack) act++;
    end
    check("R12 out-of-window activity", act, 0);
  endtask

  task automatic t_chain();
    model();
    launch(24'hC00000, 0, 16'h0, 0);
    observe(0, 0, 0, 1, 24'hE0000C, 0);
    check_frame("chain first R11", 0, 0, 0);
    observe(0, 0, 0, 0, '0, 0);
    check_frame("chain second R11", 1, 0, 0);
    check("R11 chained read data", int'(req_rdata), int'(16'(eA - 1)));
  endtask

  task automatic t_cfg_mid();
    model();
    exp_dout = 16'h0F0F;
    launch(24'hC00000, 1, 16'h0F0F, 0);
    observe(0, 0, 1, 0, '0, 0);
    check_frame("cfg mid old R14", 0, 1, 0);
    m_set = 1; m_pul = 2; m_cyc = 30;
    model();
    check("R14 new cycle len", eC, 30);
    launch(24'hC00000, 1, 16'h0F0F, 0);
    observe(0, 0, 0, 0, '0, 0);
    check_frame("cfg mid new R14", 0, 1, 0);
  endtask

  task automatic t_min_rec();
    set_cfg(2, 4, 5);
    model();
    check("R4 stretched len", eC, 9);
    launch(24'hC0000E, 0, 16'h0, 0);
    observe(0, 0, 0, 0, '0, 0);
    check_frame("min recovery R4", 0, 0, 0);
    set_cfg(1, 0, 0);
    model();
    check("R3 zero pulse len", eC, 5);
    launch(24'hC0000E, 0, 16'h0, 0);
    observe(0, 0, 0, 0, '0, 0);
    check_frame("zero pulse R3", 0, 0, 0);
  endtask

  task automatic t_wait();
    set_cfg(2, 4, 5);
    model();
    launch(24'hC00000, 0, 16'h0, 4);
    observe(4, 0, 0, 0, '0, 0);
    check_frame("ready wait R8", 0, 0, 3);
    check("R8/R7 read after wait", int'(req_rdata), int'(16'h5A00 | 16'(eA - 1 + 3)));
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_default_read();
    set_cfg(3, 5, 20);
    t_ctl_read();
    t_data_write();
    t_reg_write();
    t_data_read();
    t_busy_ignore();
    t_window();
    t_chain();
    t_cfg_mid();
    t_min_rec();
    t_wait();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule